// File: doc/BRIEF.md
# Done-Interrupt Coalescing Timers

This block sits between a DMA engine's completion events for one traffic direction and the interrupt cause logic. It does not raise a done interrupt for every completion. It holds the done cause back under two cooperating timers. The burst timer starts at the first completion that has not yet been reported, and it caps how long that completion can wait. The idle timer restarts on every completion, and it reports once the traffic has gone quiet for its threshold. The timer that expires first raises a one-cycle done pulse. That pulse returns both timers to rest until the next completion arrives.

Each timer has a control register and a threshold register. The control register holds a clear bit, an enable bit and a tick-select bit. The tick-select bit picks the unit of the threshold. When it is set, the timer counts an external one-microsecond tick. When it is clear, the timer counts core clock cycles. When neither timer is enabled, every completion reports at once.

The receive instance also watches a buffer fill level against a programmable limit. It raises a separate warning pulse that bypasses the moderation delay. Completions, ticks and register writes are plain single-cycle strobes with no back-pressure. The block has no stream interface, so no valid/ready handshake applies. Software programs the registers through a write-only port.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, both timers are disabled, both thresholds are 0, the fill limit is all ones, and `done_irq` and `warn_irq` are low.
- R2: With both timers disabled, every cycle in which `cmpl_pulse` is high is followed, on the next clock edge, by a one-cycle `done_irq` pulse.
- R3: With the burst timer enabled and threshold T greater than 0, a completion at edge k starts the burst timer if it is not running. `done_irq` rises at edge k+T in cycle-count mode. Later completions do not restart a running burst timer.
- R4: With the idle timer enabled and threshold T greater than 0, each completion reloads the idle count to zero. `done_irq` rises T counted steps after the last completion, provided no completion arrives in between.
- R5: When both timers are enabled, the first one to expire produces a single `done_irq` pulse and stops both timers. A completion in the cycle of expiry is covered by that pulse and starts nothing.
- R6: With tick select set, a timer advances only on cycles in which `us_tick` is high. With tick select clear, it advances on every cycle.
- R7: Writing a control register with bit 0 (clear) set stops that timer and zeroes its count. The clear bit is not stored, so the enable (bit 1) and tick select (bit 2) fields of the same write take effect.
- R8: A threshold of 0 on an enabled timer makes a completion report on the next edge, as in R2.
- R9: `warn_irq` pulses for one cycle on the edge after `fill_level` goes from below the limit to greater than or equal to the limit. It does not pulse again until the level has dropped below the limit.
- R10: The register addresses are 0 for burst control, 1 for burst threshold, 2 for idle control, 3 for idle threshold and 4 for the fill limit (low `FILL_W` bits). Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_pulse | input | 1 | One completion per cycle high |
| us_tick | input | 1 | External one-microsecond tick strobe |
| fill_level | input | FILL_W | Current receive buffer occupancy |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| done_irq | output | 1 | Coalesced done cause pulse |
| warn_irq | output | 1 | Early fill-level warning pulse |

## Verification
A running timer with a count that is off by one moves the `done_irq` pulse one edge early or late. A start or reload flag that gets stuck makes pulses go missing or appear twice. The bench compares every edge against a behavioural model, so either error shows up on the first report after it happens. A fill comparator that keeps stale state either repeats `warn_irq` while the level stays high, or misses the next crossing. That is visible on the edge that follows the crossing.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [2:0] {
    RA_BURST_CTL = 3'd0,
    RA_BURST_THR = 3'd1,
    RA_IDLE_CTL  = 3'd2,
    RA_IDLE_THR  = 3'd3,
    RA_FILL_LIM  = 3'd4
  } reg_addr_e;

  localparam int CTL_CLR  = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_TSEL = 2;
endpackage

// File: rtl/ic_regs.sv
module ic_regs
  import ic_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              b_en,
  output logic              b_tsel,
  output logic              b_clr,
  output logic [CNT_W-1:0]  b_thr,
  output logic              i_en,
  output logic              i_tsel,
  output logic              i_clr,
  output logic [CNT_W-1:0]  i_thr,
  output logic [FILL_W-1:0] fill_lim
);
  // clear strobes are decoded from the write, never stored
  assign b_clr = cfg_we && (cfg_addr == RA_BURST_CTL) && cfg_wdata[CTL_CLR];
  assign i_clr = cfg_we && (cfg_addr == RA_IDLE_CTL)  && cfg_wdata[CTL_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_en     <= 1'b0;
      b_tsel   <= 1'b0;
      b_thr    <= '0;
      i_en     <= 1'b0;
      i_tsel   <= 1'b0;
      i_thr    <= '0;
      fill_lim <= '1;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_BURST_CTL: begin
          b_en   <= cfg_wdata[CTL_EN];
          b_tsel <= cfg_wdata[CTL_TSEL];
        end
        RA_BURST_THR: b_thr <= cfg_wdata;
        RA_IDLE_CTL: begin
          i_en   <= cfg_wdata[CTL_EN];
          i_tsel <= cfg_wdata[CTL_TSEL];
        end
        RA_IDLE_THR:  i_thr <= cfg_wdata;
        RA_FILL_LIM:  fill_lim <= cfg_wdata[FILL_W-1:0];
        default: ;
      endcase
    end
  end

  // R10: control write lands in the enable field
  p_ctl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == RA_BURST_CTL) |=> (b_en == $past(cfg_wdata[CTL_EN])));
endmodule

// File: rtl/ic_timer.sv
module ic_timer #(
  parameter int CNT_W   = 16,
  parameter bit RESTART = 1'b0   // 1: idle timer (reload per event), 0: burst timer
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tsel,
  input  logic             clr,
  input  logic [CNT_W-1:0] thr,
  input  logic             us_tick,
  input  logic             event_in,
  input  logic             flush,
  output logic             hit
);
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             start;
  logic             keep_going;
  logic [CNT_W:0]   nxt;

  assign step = tsel ? us_tick : 1'b1;
  assign nxt  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  generate
    if (RESTART) begin : g_idle
      assign start      = event_in;
      assign keep_going = !event_in;
    end else begin : g_burst
      assign start      = event_in && !run;
      assign keep_going = 1'b1;
    end
  endgenerate

  assign hit = en && ((event_in && (thr == '0)) ||
                      (run && step && keep_going && (nxt >= {1'b0, thr})));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!en || clr || flush) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run && step) begin
      cnt <= nxt[CNT_W-1:0];
    end
  end

  // R7: clear stops and zeroes the timer
  p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!run && cnt == '0));
  // R5: a report returns the timer to rest
  p_flush_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!run && cnt == '0));
  // R6: no tick, no advance in tick mode
  p_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tsel && !us_tick && run && !clr && !flush && !event_in) |=> (cnt == $past(cnt)));

  generate
    if (RESTART) begin : g_idle_chk
      // R4: every completion reloads the idle count
      p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && event_in && !clr && !flush) |=> (run && cnt == '0));
    end
  endgenerate
endmodule

// File: rtl/ic_fill_warn.sv
module ic_fill_warn #(
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] fill_level,
  input  logic [FILL_W-1:0] fill_lim,
  output logic              warn
);
  logic above;
  logic above_q;

  assign above = (fill_level >= fill_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      warn    <= 1'b0;
    end else begin
      above_q <= above;
      warn    <= above && !above_q;
    end
  end

  // R9: warning is a single-cycle pulse
  p_warn_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn |=> !warn);
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int CNT_W    = 16,
  parameter int FILL_W   = 8,
  parameter bit HAS_WARN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_pulse,
  input  logic              us_tick,
  input  logic [FILL_W-1:0] fill_level,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              done_irq,
  output logic              warn_irq
);
  logic              b_en, b_tsel, b_clr, i_en, i_tsel, i_clr;
  logic [CNT_W-1:0]  b_thr, i_thr;
  logic [FILL_W-1:0] fill_lim;
  logic              b_hit, i_hit, fire, unmod;

  ic_regs #(.CNT_W(CNT_W), .FILL_W(FILL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .b_en(b_en), .b_tsel(b_tsel), .b_clr(b_clr),
    .b_thr(b_thr), .i_en(i_en), .i_tsel(i_tsel), .i_clr(i_clr),
    .i_thr(i_thr), .fill_lim(fill_lim)
  );

  assign unmod = !b_en && !i_en;
  assign fire  = unmod ? cmpl_pulse : (b_hit || i_hit);

  ic_timer #(.CNT_W(CNT_W), .RESTART(1'b0)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(b_en), .tsel(b_tsel), .clr(b_clr),
    .thr(b_thr), .us_tick(us_tick), .event_in(cmpl_pulse), .flush(fire),
    .hit(b_hit)
  );

  ic_timer #(.CNT_W(CNT_W), .RESTART(1'b1)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(i_en), .tsel(i_tsel), .clr(i_clr),
    .thr(i_thr), .us_tick(us_tick), .event_in(cmpl_pulse), .flush(fire),
    .hit(i_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_irq <= 1'b0;
    else        done_irq <= fire;
  end

  generate
    if (HAS_WARN) begin : g_warn
      ic_fill_warn #(.FILL_W(FILL_W)) u_warn (
        .clk(clk), .rst_n(rst_n), .fill_level(fill_level),
        .fill_lim(fill_lim), .warn(warn_irq)
      );
    end else begin : g_nowarn
      assign warn_irq = 1'b0;
    end
  endgenerate

  // R2: without moderation each completion reports next edge
  p_unmod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unmod && cmpl_pulse) |=> done_irq);
  // R8: zero threshold reports next edge
  p_zero_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_thr == '0 && cmpl_pulse) |=> done_irq);
endmodule

// File: tb/sim_irq_coalesce.sv
`timescale 1ns/1ps
module sim_irq_coalesce;
  localparam int CNT_W  = 16;
  localparam int FILL_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmpl_pulse = 1'b0;
  logic              us_tick = 1'b0;
  logic [FILL_W-1:0] fill_level = '0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [CNT_W-1:0]  cfg_wdata = '0;
  logic              done_irq, warn_irq;

  int    checks = 0;
  int    errors = 0;
  bit    tick_on = 1'b0;
  bit    finished = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  irq_coalesce #(.CNT_W(CNT_W), .FILL_W(FILL_W), .HAS_WARN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse), .us_tick(us_tick),
    .fill_level(fill_level), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .done_irq(done_irq), .warn_irq(warn_irq)
  );

  // behavioural reference
  int m_ben, m_btsel, m_bthr, m_ien, m_itsel, m_ithr, m_lim;
  int m_brun, m_bcnt, m_irun, m_icnt, m_above_q;
  bit exp_done = 1'b0;
  bit exp_warn = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ben = 0; m_btsel = 0; m_bthr = 0; m_ien = 0; m_itsel = 0; m_ithr = 0;
      m_lim = 255; m_brun = 0; m_bcnt = 0; m_irun = 0; m_icnt = 0; m_above_q = 0;
      exp_done = 1'b0; exp_warn = 1'b0;
    end else begin
      int  sb, si, above;
      bit  hb, hi, f, cb, ci;
      sb = m_btsel ? int'(us_tick) : 1;
      si = m_itsel ? int'(us_tick) : 1;
      hb = (m_ben != 0) && ((cmpl_pulse && m_bthr == 0) ||
           (m_brun != 0 && sb != 0 && m_bcnt + 1 >= m_bthr));
      hi = (m_ien != 0) && ((cmpl_pulse && m_ithr == 0) ||
           (m_irun != 0 && !cmpl_pulse && si != 0 && m_icnt + 1 >= m_ithr));
      f  = (m_ben == 0 && m_ien == 0) ? cmpl_pulse : (hb || hi);
      cb = cfg_we && cfg_addr == 3'd0 && cfg_wdata[0];
      ci = cfg_we && cfg_addr == 3'd2 && cfg_wdata[0];
      exp_done = f;
      // burst timer
      if (m_ben == 0 || cb || f) begin m_brun = 0; m_bcnt = 0; end
      else if (cmpl_pulse && m_brun == 0) begin m_brun = 1; m_bcnt = 0; end
      else if (m_brun != 0 && sb != 0) m_bcnt++;
      // idle timer
      if (m_ien == 0 || ci || f) begin m_irun = 0; m_icnt = 0; end
      else if (cmpl_pulse) begin m_irun = 1; m_icnt = 0; end
      else if (m_irun != 0 && si != 0) m_icnt++;
      // fill warning
      above = (int'(fill_level) >= m_lim) ? 1 : 0;
      exp_warn = (above != 0) && (m_above_q == 0);
      m_above_q = above;
      // register writes
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_ben = int'(cfg_wdata[1]); m_btsel = int'(cfg_wdata[2]); end
          3'd1: m_bthr = int'(cfg_wdata);
          3'd2: begin m_ien = int'(cfg_wdata[1]); m_itsel = int'(cfg_wdata[2]); end
          3'd3: m_ithr = int'(cfg_wdata);
          3'd4: m_lim = int'(cfg_wdata[FILL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  // per-edge comparison away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        checks++;
        if (done_irq !== exp_done) begin
          errors++;
          $display("FAIL %s done_irq actual=%b expected=%b t=%0t", tag, done_irq, exp_done, $time);
        end
        checks++;
        if (warn_irq !== exp_warn) begin
          errors++;
          $display("FAIL %s warn_irq actual=%b expected=%b t=%0t", tag, warn_irq, exp_warn, $time);
        end
      end
    end
  end

  // microsecond tick source: one strobe every 5 cycles while enabled
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (tick_on) begin
        div = (div + 1) % 5;
        us_tick = (div == 0);
      end else begin
        us_tick = 1'b0;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmpl();
    cmpl_pulse = 1'b1;
    @(negedge clk);
    cmpl_pulse = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [CNT_W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: outputs quiet in and after reset
    cyc(3);
    checks++;
    if (done_irq !== 1'b0 || warn_irq !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b%b expected=00", done_irq, warn_irq);
    end
    rst_n = 1'b1;
    cyc(4);

    // R2: unmoderated, single and back-to-back completions
    tag = "R2";
    cmpl(); cyc(3);
    cmpl(); cmpl(); cmpl(); cyc(4);

    // R3: burst only, threshold 4, cycle mode
    tag = "R3";
    wreg(3'd1, 16'd4);
    wreg(3'd0, 16'h0002);
    cmpl(); cyc(1); cmpl(); cyc(8);
    cmpl(); cmpl(); cmpl(); cmpl(); cmpl(); cmpl(); cyc(8);

    // R4: idle only, threshold 3
    tag = "R4";
    wreg(3'd0, 16'h0001);
    wreg(3'd3, 16'd3);
    wreg(3'd2, 16'h0002);
    cmpl(); cyc(1); cmpl(); cyc(1); cmpl(); cyc(6);
    cmpl(); cyc(2); cmpl(); cyc(6);

    // R5: both armed, steady traffic so the burst cap wins
    tag = "R5";
    wreg(3'd1, 16'd6);
    wreg(3'd0, 16'h0002);
    for (int i = 0; i < 8; i++) begin cmpl(); cyc(1); end
    cyc(6);
    for (int i = 0; i < 5; i++) cmpl();
    cyc(8);

    // R6: tick mode on the burst timer
    tag = "R6";
    wreg(3'd2, 16'h0001);
    wreg(3'd1, 16'd2);
    wreg(3'd0, 16'h0006);
    tick_on = 1'b1;
    cyc(2); cmpl(); cyc(15);
    cmpl(); cyc(3); cmpl(); cyc(15);
    tick_on = 1'b0;

    // R7: clear a running burst timer mid-count
    tag = "R7";
    wreg(3'd1, 16'd5);
    wreg(3'd0, 16'h0002);
    cmpl(); cyc(2);
    wreg(3'd0, 16'h0003);
    cyc(8);
    cmpl(); cyc(2);
    wreg(3'd0, 16'h0001);
    cyc(6);

    // R8: zero thresholds report at once
    tag = "R8";
    wreg(3'd1, 16'd0);
    wreg(3'd0, 16'h0002);
    cmpl(); cyc(2); cmpl(); cmpl(); cyc(3);
    wreg(3'd0, 16'h0001);
    wreg(3'd3, 16'd0);
    wreg(3'd2, 16'h0002);
    cmpl(); cyc(3);

    // R10: writes to unused addresses are ignored
    tag = "R10";
    wreg(3'd3, 16'd2);
    wreg(3'd5, 16'hFFFF);
    wreg(3'd6, 16'hFFFF);
    wreg(3'd7, 16'hFFFF);
    cmpl(); cyc(6);

    // R9: fill-level crossing warning
    tag = "R9";
    wreg(3'd4, 16'd10);
    for (int v = 0; v < 14; v++) begin fill_level = FILL_W'(v); cyc(1); end
    cyc(3);
    fill_level = 8'd9; cyc(2);
    fill_level = 8'd10; cyc(3);
    fill_level = 8'd200; cyc(3);
    fill_level = 8'd0; cyc(2);
    fill_level = 8'd255; cyc(3);

    cyc(2);
    finish_run();
  end
endmodule